// File: doc/BRIEF.md
# Streamed-Input Threshold Unit

This block is one functional unit of a classifier that receives its input vector as a stream of addressed data elements, one element per clock cycle. The unit holds three configuration fields in ordinary registers: the element address it listens for, a constant to compare against, and a one-bit function select. When a valid element arrives whose address equals the configured address, the unit tests whether the element is greater than the constant. It optionally inverts that result, and the chosen bit is captured in a one-bit result register that drives the output.

Each unit picks its element with an address-equality enable on the result register, instead of a wide multiplexer over the whole vector. Both functions come from one comparator. The greater-than result passes straight through or is inverted to give less-or-equal. The configuration is written through a parallel port and changes the unit's behaviour from the next cycle on. A synchronous clear zeroes the result at the start of each new vector.

Top module: `thr_unit`

## Requirements
- R1: While the active-low reset is asserted, the result output is 0 and all configuration fields are 0 (address 0, constant 0, function 0 = greater-than).
- R2: If on a clock edge the clear is low and the element is not valid, or its address differs from the configured address, the result output keeps its value.
- R3: If on a clock edge the clear is low, the element is valid and its address equals the configured address, the output becomes the compare result from that edge on. With function select 0 the result is 1 when data > constant (unsigned). With function select 1 the result is 1 when data <= constant.
- R4: A clear that is high on a clock edge sets the output to 0 from that edge, even if a matching valid element is present in the same cycle.
- R5: A configuration write (write enable high on a clock edge) loads address, function and constant together. Elements on later edges use the new values, and an element on the same edge as the write still uses the previous values.
- R6: A configuration write does not change the result output by itself.
- R7: Address matching compares every address bit. An element whose address differs from the configured one in any single bit is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W (6) | Element address to listen for |
| cfg_func | input | 1 | Function select: 0 greater-than, 1 less-or-equal |
| cfg_const | input | DATA_W (6) | Comparison constant |
| vec_clr | input | 1 | Synchronous clear of the result, start of vector |
| el_valid | input | 1 | Streamed element is valid this cycle |
| el_addr | input | ADDR_W (6) | Address of the streamed element |
| el_data | input | DATA_W (6) | Value of the streamed element |
| fu_out | output | 1 | Registered unit result |

## Verification
On every cycle the assertions check that the output holds when nothing matches, that it takes the correct compare result after a matching valid element, that a clear wins and gives 0, and that a configuration write is loaded on its edge without moving the output. Only the bench scenarios show the rest. They sweep every constant against every data value for both functions and show that a write and an element on the same edge use the old configuration. They also flip each address bit to show that near-miss addresses are rejected, and check the values held during reset at the ports.

// File: rtl/thr_pkg.sv
package thr_pkg;
   typedef enum logic {
      FN_GT = 1'b0,
      FN_LE = 1'b1
   } thr_func_e;
endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              func_d,
   input  logic [DATA_W-1:0] const_d,
   output logic [ADDR_W-1:0] addr_q,
   output thr_pkg::thr_func_e func_q,
   output logic [DATA_W-1:0] const_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         func_q  <= thr_pkg::FN_GT;
         const_q <= '0;
      end else if (we) begin
         addr_q  <= addr_d;
         func_q  <= thr_pkg::thr_func_e'(func_d);
         const_q <= const_d;
      end
   end
endmodule

// File: rtl/thr_addr_match.sv
module thr_addr_match #(
   parameter int ADDR_W      = 6,
   parameter bit SPLIT_MATCH = 1'b1
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   output logic              eq
);
   localparam int LO_W = ADDR_W / 2;
   localparam int HI_W = ADDR_W - LO_W;

   generate
      if (SPLIT_MATCH && ADDR_W > 1) begin : g_split
         logic eq_hi;
         logic eq_lo;
         assign eq_hi = (a[ADDR_W-1:LO_W] == b[ADDR_W-1:LO_W]);
         assign eq_lo = (a[LO_W-1:0] == b[LO_W-1:0]);
         assign eq    = eq_hi & eq_lo;
      end else begin : g_flat
         assign eq = (a == b);
      end
   endgenerate

   generate
      if (HI_W < 1) begin : g_bad_w
         $error("thr_addr_match: address width too small");
      end
   endgenerate
endmodule

// File: rtl/thr_cmp.sv
module thr_cmp #(
   parameter int DATA_W = 6
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [DATA_W-1:0]  cst,
   input  thr_pkg::thr_func_e func,
   output logic               bit_o
);
   logic gt;
   assign gt    = (data > cst);
   assign bit_o = (func == thr_pkg::FN_LE) ? ~gt : gt;
endmodule

// File: rtl/thr_unit.sv
module thr_unit #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 6,
   parameter bit SPLIT_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_func,
   input  logic [DATA_W-1:0] cfg_const,
   input  logic              vec_clr,
   input  logic              el_valid,
   input  logic [ADDR_W-1:0] el_addr,
   input  logic [DATA_W-1:0] el_data,
   output logic              fu_out
);
   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("thr_unit: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
         $error("thr_unit: DATA_W out of range");
      end
   endgenerate

   logic [ADDR_W-1:0]  addr_q;
   thr_pkg::thr_func_e func_q;
   logic [DATA_W-1:0]  const_q;
   logic               hit;
   logic               cmp_bit;
   logic               res_q;

   thr_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .addr_d(cfg_addr), .func_d(cfg_func), .const_d(cfg_const),
      .addr_q(addr_q), .func_q(func_q), .const_q(const_q)
   );

   thr_addr_match #(.ADDR_W(ADDR_W), .SPLIT_MATCH(SPLIT_MATCH)) u_match (
      .a(el_addr), .b(addr_q), .eq(hit)
   );

   thr_cmp #(.DATA_W(DATA_W)) u_cmp (
      .data(el_data), .cst(const_q), .func(func_q), .bit_o(cmp_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                res_q <= 1'b0;
      else if (vec_clr)          res_q <= 1'b0;
      else if (el_valid && hit)  res_q <= cmp_bit;
   end

   assign fu_out = res_q;
endmodule

// File: rtl/thr_unit_chk.sv
module thr_unit_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              cfg_func,
   input logic [DATA_W-1:0] cfg_const,
   input logic              vec_clr,
   input logic              el_valid,
   input logic [ADDR_W-1:0] el_addr,
   input logic [DATA_W-1:0] el_data,
   input logic              fu_out,
   input logic [ADDR_W-1:0] addr_q,
   input logic              func_bit,
   input logic [DATA_W-1:0] const_q
);
   // R2
   a_r2_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_clr && !(el_valid && el_addr == addr_q)) |=> $stable(fu_out));

   // R3
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_clr && el_valid && el_addr == addr_q)
      |=> fu_out == (($past(el_data) > $past(const_q)) ^ $past(func_bit)));

   // R4
   a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      vec_clr |=> !fu_out);

   // R5
   a_r5_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (addr_q == $past(cfg_addr) && const_q == $past(cfg_const)
                  && func_bit == $past(cfg_func)));

   // R6
   a_r6_cfg_no_disturb: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !vec_clr && !el_valid) |=> $stable(fu_out));
endmodule

bind thr_unit thr_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_func(cfg_func), .cfg_const(cfg_const), .vec_clr(vec_clr),
   .el_valid(el_valid), .el_addr(el_addr), .el_data(el_data),
   .fu_out(fu_out), .addr_q(addr_q), .func_bit(func_q), .const_q(const_q)
);

// File: tb/sim_thr_unit.sv
`timescale 1ns/1ps
module sim_thr_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic          cfg_func = 1'b0;
   logic [DW-1:0] cfg_const = '0;
   logic          vec_clr = 1'b0;
   logic          el_valid = 1'b0;
   logic [AW-1:0] el_addr = '0;
   logic [DW-1:0] el_data = '0;
   logic          fu_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   thr_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_func(cfg_func), .cfg_const(cfg_const), .vec_clr(vec_clr),
      .el_valid(el_valid), .el_addr(el_addr), .el_data(el_data),
      .fu_out(fu_out)
   );

   function automatic logic ref_bit(int d, int c, int f);
      return (f != 0) ? (d <= c) : (d > c);
   endfunction

   task automatic check(string req, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: fu_out=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // inputs change at negedge; outputs sampled at the following negedge
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      cfg_we = 1'b0; vec_clr = 1'b0; el_valid = 1'b0;
   endtask

   task automatic write_cfg(int a, int f, int c);
      cfg_we = 1'b1; cfg_addr = AW'(a); cfg_func = f[0]; cfg_const = DW'(c);
      tick();
      idle();
   endtask

   task automatic send(int a, int d);
      el_valid = 1'b1; el_addr = AW'(a); el_data = DW'(d);
      tick();
      idle();
   endtask

   task automatic clear();
      vec_clr = 1'b1;
      tick();
      idle();
   endtask

   initial begin
      logic e;
      // R1: outputs during reset
      tick(); tick();
      check("R1", fu_out, 1'b0);
      rst_n = 1'b1;
      tick();
      // R1: reset config is addr 0, GT, const 0: data 1 at addr 0 gives 1
      send(0, 1);
      check("R1", fu_out, 1'b1);
      send(0, 0);
      check("R1", fu_out, 1'b0);

      // R3: exhaustive sweep of function x constant x data
      for (int f = 0; f < 2; f++) begin
         for (int c = 0; c < 64; c++) begin
            write_cfg(c ^ 21, f, c);
            for (int d = 0; d < 64; d++) begin
               send(c ^ 21, d);
               check("R3", fu_out, ref_bit(d, c, f));
            end
         end
      end

      // R2: valid low with matching address is ignored
      write_cfg(9, 0, 30);
      send(9, 50);
      check("R3", fu_out, 1'b1);
      el_valid = 1'b0; el_addr = 6'd9; el_data = 6'd2;
      tick();
      check("R2", fu_out, 1'b1);
      // R2/R7: every other address ignored, each single-bit flip rejected
      for (int a = 0; a < 64; a++) begin
         if (a != 9) begin
            send(a, 2);
            check("R2", fu_out, 1'b1);
         end
      end
      for (int b = 0; b < AW; b++) begin
         send(9 ^ (1 << b), 0);
         check("R7", fu_out, 1'b1);
      end

      // R4: clear gives 0, and wins over a matching element
      clear();
      check("R4", fu_out, 1'b0);
      send(9, 63);
      check("R3", fu_out, 1'b1);
      vec_clr = 1'b1; el_valid = 1'b1; el_addr = 6'd9; el_data = 6'd63;
      tick();
      idle();
      check("R4", fu_out, 1'b0);

      // R6: config write leaves output untouched (both levels)
      write_cfg(3, 1, 10);
      check("R6", fu_out, 1'b0);
      send(3, 5);
      check("R3", fu_out, 1'b1);
      write_cfg(40, 0, 63);
      check("R6", fu_out, 1'b1);

      // R5: write and element on the same edge use old config (addr 40, GT, 63)
      cfg_we = 1'b1; cfg_addr = 6'd40; cfg_func = 1'b1; cfg_const = 6'd0;
      el_valid = 1'b1; el_addr = 6'd40; el_data = 6'd20;
      tick();
      idle();
      e = ref_bit(20, 63, 0);
      check("R5", fu_out, e);
      // next edge uses new config (LE, 0): 20 <= 0 false, 0 <= 0 true
      send(40, 0);
      check("R5", fu_out, 1'b1);
      send(40, 20);
      check("R5", fu_out, 1'b0);
      // old address no longer matches after address change
      write_cfg(41, 1, 63);
      send(40, 1);
      check("R5", fu_out, 1'b0);
      send(41, 1);
      check("R5", fu_out, 1'b1);

      // R1: reset mid-run clears output and config
      rst_n = 1'b0;
      tick();
      check("R1", fu_out, 1'b0);
      rst_n = 1'b1;
      tick();
      send(41, 1);
      check("R1", fu_out, 1'b0);
      send(0, 5);
      check("R1", fu_out, 1'b1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule